// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block builds the 16-bit physical address for each memory access of a small 8-bit processor. It keeps four 8-bit segment registers, one each for code, data, extra and stack. A request gives an access kind (instruction fetch, ordinary data access or stack push/pop), an extra-segment override bit and an 8-bit offset. The block picks a segment from the kind and the override bit. The selected segment becomes the upper byte of the address and the offset becomes the lower byte.

The result is registered, so it appears one clock after the request. The block also gives the address of the second byte, which a two-byte access uses, and passes a wide-access flag through. Segment registers are written one at a time through a plain write port. A far-jump port loads the code segment and hands a new instruction-pointer byte to the register file in the same step. The two bytes of a far jump arrive as one 16-bit word: the byte at the lower address goes to the code segment and the byte at the higher address goes to the instruction pointer.

Top module: `seg_addr_gen`

## Requirements
- R1: One clock after an accepted request (`req_valid` high), `addr_valid` is high and `addr` equals {selected segment, `req_offset`}, with the segment in bits 15:8.
- R2: Kind 0 (fetch) always selects the code segment, whatever the override bit says. `seg_used` reports 0.
- R3: Kind 1 (data), and the reserved kind 3, select the data segment (`seg_used` = 1). With `req_extra` set they select the extra segment (`seg_used` = 2).
- R4: Kind 2 (stack) selects the stack segment (`seg_used` = 3). With `req_extra` set it selects the extra segment (`seg_used` = 2).
- R5: Alongside `addr`, `addr_next` equals `addr` + 1 modulo 2^16, so 0xFFFF is followed by 0x0000. `addr_wide` repeats `req_wide`.
- R6: When `seg_we` is high, the segment named by `seg_sel` (0 code, 1 data, 2 extra, 3 stack) takes `seg_wdata` at the clock edge. A request in that same cycle still uses the old value. The next request uses the new value.
- R7: When `far_we` is high, the code segment takes `far_word[7:0]`. One clock later `ip_load_en` is high and `ip_load_data` equals `far_word[15:8]`. When `seg_we` targets the code segment in the same cycle, the far jump takes priority.
- R8: Synchronous reset clears all four segments to zero and drives `addr_valid` and `ip_load_en` low. A fetch at offset 0 after reset addresses 0x0000.
- R9: One clock after a cycle with `req_valid` low, `addr_valid` is low and `addr`, `addr_next`, `addr_wide` and `seg_used` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request this cycle |
| req_kind | input | 2 | Access kind: 0 fetch, 1 data, 2 stack, 3 treated as data |
| req_extra | input | 1 | Extra-segment override for data and stack accesses |
| req_offset | input | 8 | Offset within the segment |
| req_wide | input | 1 | Two-byte access flag |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment to write: 0 code, 1 data, 2 extra, 3 stack |
| seg_wdata | input | 8 | Segment write value |
| far_we | input | 1 | Far jump: load code segment and instruction pointer |
| far_word | input | 16 | [7:0] new code segment, [15:8] new instruction pointer |
| addr_valid | output | 1 | Address outputs updated this cycle |
| addr | output | 16 | Physical address of the first byte |
| addr_next | output | 16 | Physical address of the second byte |
| addr_wide | output | 1 | Registered copy of the wide flag |
| seg_used | output | 2 | Segment that formed the address |
| ip_load_en | output | 1 | Instruction pointer load strobe |
| ip_load_data | output | 8 | New instruction pointer value |

## Verification
Random requests cover every access kind with the override bit both clear and set. Each sample exposes a wrong segment choice through `seg_used` and also through the upper address byte, because the bench keeps every segment at a distinct random value. Segment writes, far jumps and idle cycles are mixed in at random. A stale segment, a write to the wrong register, or an output that moves while idle therefore shows up in a later address. Directed cases add several checks:
- a request in the same cycle as a write to the segment it uses, which tells old-value from new-value forwarding;
- a far jump and a code-segment write in the same cycle, which tells which one takes priority;
- a 0xFFFF access, which tells a wrapping second-byte address from one that carries out of 16 bits.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NUM_SEGS = 4;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_STACK = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_STACK = 2'd3
  } seg_id_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [SEG_W-1:0]          wr_data,
  input  logic                      far_en,
  input  logic [SEG_W-1:0]          far_seg,
  output logic [NUM_SEGS*SEG_W-1:0] seg_flat
);
  // One register per segment; the far jump owns the code segment write.
  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
    logic [SEG_W-1:0] seg_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        seg_q <= '0;
      end else if (far_en && (i == int'(SEG_CODE))) begin
        seg_q <= far_seg;
      end else if (wr_en && (wr_sel == 2'(i))) begin
        seg_q <= wr_data;
      end
    end
    assign seg_flat[i*SEG_W +: SEG_W] = seg_q;
  end

  // R7: far jump lands in the code segment even against a plain write
  assert_far_code_R7: assert property (@(posedge clk) disable iff (rst)
    far_en |=> seg_flat[int'(SEG_CODE)*SEG_W +: SEG_W] == $past(far_seg));

  // R6: a plain write to the extra segment lands on the next edge
  assert_extra_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEG_EXTRA) |=>
      seg_flat[int'(SEG_EXTRA)*SEG_W +: SEG_W] == $past(wr_data));
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic [1:0]                kind,
  input  logic                      extra,
  input  logic [NUM_SEGS*SEG_W-1:0] seg_flat,
  output logic [1:0]                sel_id,
  output logic [SEG_W-1:0]          sel_seg
);
  seg_id_e id;

  always_comb begin
    case (acc_kind_e'(kind))
      KIND_FETCH: id = SEG_CODE;
      KIND_STACK: id = extra ? SEG_EXTRA : SEG_STACK;
      default:    id = extra ? SEG_EXTRA : SEG_DATA;
    endcase
  end

  assign sel_id  = id;
  assign sel_seg = seg_flat[int'(id)*SEG_W +: SEG_W];

  // R2: a fetch never reports another segment
  always_comb begin
    if (kind == KIND_FETCH) assert_fetch_code_R2: assert (sel_id == SEG_CODE);
  end
endmodule

// File: rtl/addr_pipe.sv
module addr_pipe #(
  parameter int SEG_W = 8,
  parameter int OFF_W = 8,
  parameter int IP_W  = 8,
  localparam int ADDR_W = SEG_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic [OFF_W-1:0]  in_off,
  input  logic              in_wide,
  input  logic [1:0]        in_id,
  input  logic              far_en,
  input  logic [IP_W-1:0]   far_ip,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_next,
  output logic              out_wide,
  output logic [1:0]        out_id,
  output logic              ip_en,
  output logic [IP_W-1:0]   ip_data
);
  logic [ADDR_W-1:0] phys;
  assign phys = {in_seg, in_off};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_next  <= '0;
      out_wide  <= 1'b0;
      out_id    <= '0;
      ip_en     <= 1'b0;
      ip_data   <= '0;
    end else begin
      out_valid <= in_valid;
      ip_en     <= far_en;
      if (in_valid) begin
        out_addr <= phys;
        out_next <= phys + ADDR_W'(1);
        out_wide <= in_wide;
        out_id   <= in_id;
      end
      if (far_en) ip_data <= far_ip;
    end
  end

  // R7: instruction pointer strobe follows a far jump by one clock
  assert_ip_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    far_en |=> ip_en && ip_data == $past(far_ip));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 8,
  parameter int IP_W  = 8,
  localparam int ADDR_W = SEG_W + OFF_W,
  localparam int FAR_W  = SEG_W + IP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_extra,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              req_wide,
  input  logic              seg_we,
  input  logic [1:0]        seg_sel,
  input  logic [SEG_W-1:0]  seg_wdata,
  input  logic              far_we,
  input  logic [FAR_W-1:0]  far_word,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_next,
  output logic              addr_wide,
  output logic [1:0]        seg_used,
  output logic              ip_load_en,
  output logic [IP_W-1:0]   ip_load_data
);
  logic [NUM_SEGS*SEG_W-1:0] seg_flat;
  logic [1:0]                sel_id;
  logic [SEG_W-1:0]          sel_seg;

  seg_bank #(.SEG_W(SEG_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (seg_we),
    .wr_sel   (seg_sel),
    .wr_data  (seg_wdata),
    .far_en   (far_we),
    .far_seg  (far_word[SEG_W-1:0]),
    .seg_flat (seg_flat)
  );

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .kind     (req_kind),
    .extra    (req_extra),
    .seg_flat (seg_flat),
    .sel_id   (sel_id),
    .sel_seg  (sel_seg)
  );

  addr_pipe #(.SEG_W(SEG_W), .OFF_W(OFF_W), .IP_W(IP_W)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_seg    (sel_seg),
    .in_off    (req_offset),
    .in_wide   (req_wide),
    .in_id     (sel_id),
    .far_en    (far_we),
    .far_ip    (far_word[FAR_W-1:SEG_W]),
    .out_valid (addr_valid),
    .out_addr  (addr),
    .out_next  (addr_next),
    .out_wide  (addr_wide),
    .out_id    (seg_used),
    .ip_en     (ip_load_en),
    .ip_data   (ip_load_data)
  );

  // R1: low address byte carries the request offset
  assert_offset_low_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid && addr[OFF_W-1:0] == $past(req_offset));

  // R3: overridden data access reports the extra segment
  assert_data_extra_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_extra && (req_kind == KIND_DATA || req_kind == KIND_RSVD))
      |=> seg_used == SEG_EXTRA);

  // R4: stack access without override reports the stack segment
  assert_stack_plain_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_extra && req_kind == KIND_STACK) |=> seg_used == SEG_STACK);

  // R9: idle cycles leave the address outputs untouched
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid && $stable(addr) && $stable(addr_next) && $stable(seg_used));

  // R8: reset quiets both strobes
  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> !addr_valid && !ip_load_en);
endmodule

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        req_extra = 1'b0;
  logic [7:0]  req_offset = '0;
  logic        req_wide = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_sel = '0;
  logic [7:0]  seg_wdata = '0;
  logic        far_we = 1'b0;
  logic [15:0] far_word = '0;
  logic        addr_valid;
  logic [15:0] addr, addr_next;
  logic        addr_wide;
  logic [1:0]  seg_used;
  logic        ip_load_en;
  logic [7:0]  ip_load_data;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0]  m_seg [4];
  logic        e_valid, e_wide, e_ip_en;
  logic [15:0] e_addr, e_next;
  logic [1:0]  e_id;
  logic [7:0]  e_ip;

  always #4 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_extra(req_extra), .req_offset(req_offset), .req_wide(req_wide),
    .seg_we(seg_we), .seg_sel(seg_sel), .seg_wdata(seg_wdata),
    .far_we(far_we), .far_word(far_word), .addr_valid(addr_valid),
    .addr(addr), .addr_next(addr_next), .addr_wide(addr_wide),
    .seg_used(seg_used), .ip_load_en(ip_load_en), .ip_load_data(ip_load_data)
  );

  function automatic logic [1:0] pick_seg(logic [1:0] kind, logic extra);
    if (kind == 2'd0) return 2'd0;
    if (kind == 2'd2) return extra ? 2'd2 : 2'd3;
    return extra ? 2'd2 : 2'd1;
  endfunction

  function automatic string kind_req(logic [1:0] kind);
    if (kind == 2'd0) return "R2";
    if (kind == 2'd2) return "R4";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One clock: compute expectations from the model at the edge, then check.
  task automatic step(input string addr_tag);
    logic [1:0] id;
    @(posedge clk);
    id = pick_seg(req_kind, req_extra);
    e_valid = req_valid;
    e_ip_en = far_we;
    if (req_valid) begin
      e_addr = {m_seg[id], req_offset};
      e_next = e_addr + 16'd1;
      e_wide = req_wide;
      e_id   = id;
    end
    if (far_we) e_ip = far_word[15:8];
    if (far_we) m_seg[0] = far_word[7:0];
    if (seg_we && !(far_we && seg_sel == 2'd0)) m_seg[seg_sel] = seg_wdata;
    @(negedge clk);
    chk(addr_valid == e_valid, "R9", "addr_valid", addr_valid, e_valid);
    if (e_valid) begin
      chk(addr == e_addr, addr_tag, "addr", addr, e_addr);
      chk(seg_used == e_id, kind_req(e_id == 2'd0 ? 2'd0 : (e_id == 2'd3 || (e_id == 2'd2 && req_kind == 2'd2)) ? 2'd2 : 2'd1),
          "seg_used", seg_used, e_id);
      chk(addr_next == e_next, "R5", "addr_next", addr_next, e_next);
      chk(addr_wide == e_wide, "R5", "addr_wide", addr_wide, e_wide);
    end else begin
      chk(addr == e_addr && addr_next == e_next && seg_used == e_id,
          "R9", "held addr", addr, e_addr);
    end
    chk(ip_load_en == e_ip_en, "R7", "ip_load_en", ip_load_en, e_ip_en);
    if (e_ip_en) chk(ip_load_data == e_ip, "R7", "ip_load_data", ip_load_data, e_ip);
  endtask

  task automatic idle_inputs();
    req_valid = 0; seg_we = 0; far_we = 0; req_extra = 0; req_wide = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 4; i++) m_seg[i] = 8'h00;
    e_addr = '0; e_next = '0; e_id = '0; e_wide = 0; e_ip = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(addr_valid == 1'b0, "R8", "addr_valid in reset", addr_valid, 0);
    chk(ip_load_en == 1'b0, "R8", "ip_load_en in reset", ip_load_en, 0);
    rst = 0;
    // R8: first fetch at offset 0 lands on 0x0000
    req_valid = 1; req_kind = 2'd0; req_offset = 8'h00; req_extra = 1;
    step("R8");
    chk(addr == 16'h0000, "R8", "first fetch", addr, 0);

    // give every segment a distinct value
    idle_inputs();
    for (int i = 0; i < 4; i++) begin
      seg_we = 1; seg_sel = 2'(i); seg_wdata = 8'(8'h31 + 8'(i) * 8'h22);
      step("R1");
    end
    idle_inputs();

    // R6: same-cycle write and request use the old data segment
    req_valid = 1; req_kind = 2'd1; req_offset = 8'h40;
    seg_we = 1; seg_sel = 2'd1; seg_wdata = 8'hC7;
    step("R6");
    seg_we = 0;
    step("R6");
    chk(addr == 16'hC740, "R6", "new data segment", addr, 16'hC740);

    // R5: wrap of the second-byte address
    seg_we = 1; seg_sel = 2'd3; seg_wdata = 8'hFF; req_valid = 0;
    step("R1");
    seg_we = 0; req_valid = 1; req_kind = 2'd2; req_offset = 8'hFF; req_wide = 1;
    step("R5");
    chk(addr_next == 16'h0000, "R5", "wrap", addr_next, 0);

    // R7: far jump beats a code-segment write in the same cycle
    req_valid = 0; req_wide = 0;
    far_we = 1; far_word = 16'h5AA3; seg_we = 1; seg_sel = 2'd0; seg_wdata = 8'h11;
    step("R1");
    idle_inputs();
    req_valid = 1; req_kind = 2'd0; req_offset = 8'h07;
    step("R7");
    chk(addr == 16'hA307, "R7", "code after far jump", addr, 16'hA307);

    // random mix
    for (int n = 0; n < 400; n++) begin
      req_valid  = ($urandom % 5) != 0;
      req_kind   = 2'($urandom);
      req_extra  = 1'($urandom);
      req_offset = 8'($urandom);
      req_wide   = 1'($urandom);
      seg_we     = ($urandom % 5) == 0;
      seg_sel    = 2'($urandom);
      seg_wdata  = 8'($urandom);
      far_we     = ($urandom % 10) == 0;
      far_word   = 16'($urandom);
      step("R1");
    end
    idle_inputs();
    step("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule